// File: doc/BRIEF.md
# Power-up recall sequencer

This block brings a nonvolatile-backed SRAM array back to a usable state after the supply has been lost or has sagged. Two digital comparator flags describe the supply. One says the supply is above the low reset level. The other says it is above the higher switch level. Whenever the supply is below the reset level, and always out of reset, a pending restore request is held. The restore is not launched at that point. It starts only when the supply is also above the switch level.

A launched restore runs in two phases. The first phase wipes the array by asserting a clear command for a fixed number of cycles. The second phase asserts a transfer command until the copy engine reports completion. The restore only ever writes the array. Normal reads and writes stay blocked until a fixed restore window, counted from the launch edge, has elapsed and the copy has finished.

Writes that arrive during a restore are dropped and raise a sticky error flag. A drop below the reset level at any time aborts the sequence and arms a new request. The write-dirty flag seen by the store logic is set by accepted writes and cleared when a restore completes.

Top module: `prs_recall_seq`

## Requirements
- R1: After reset, clear_o, xfer_o, ready_o, wr_err_o and dirty_o are 0 and a restore request is pending.
- R2: A restore is launched on the clock edge that follows a cycle in which a request is pending and both above_reset_i and above_switch_i are 1. With above_switch_i at 0 the block stays idle and raises no command.
- R3: clear_o rises on the launch edge and stays 1 for exactly CLEAR_CYCLES cycles. On the edge where it falls, xfer_o rises. At most one of clear_o, xfer_o and ready_o is 1 at any time.
- R4: If xfer_done_i is sampled 1 early, xfer_o falls on the next edge and ready_o rises exactly RECALL_CYCLES edges after the launch edge.
- R5: If xfer_done_i is first sampled 1 at or after the end of the restore window, xfer_o falls and ready_o rises together on the edge that samples it.
- R6: rd_en_o equals rd_req_i and wr_en_o equals wr_req_i only while ready_o and above_reset_i are both 1. Otherwise both are 0.
- R7: A wr_req_i sampled while a restore is in progress (clear, transfer or wait for window) is not passed to wr_en_o. It sets wr_err_o, which then stays 1 until rst_ni.
- R8: If above_reset_i is sampled 0 during a restore, clear_o and xfer_o drop on that edge. The next launch again needs both flags high and runs the full clear phase and window.
- R9: If above_reset_i is sampled 0 while ready, ready_o falls on that edge and a new restore follows when the supply returns. Restores repeat any number of times.
- R10: dirty_o is set by a write accepted on wr_en_o and is 0 from the edge on which ready_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| above_reset_i | input | 1 | Supply is above the reset level |
| above_switch_i | input | 1 | Supply is above the switch level |
| xfer_done_i | input | 1 | Copy engine has finished the transfer |
| rd_req_i | input | 1 | Array read request |
| wr_req_i | input | 1 | Array write request |
| clear_o | output | 1 | Wipe-array command (phase 1) |
| xfer_o | output | 1 | Copy-to-array command (phase 2) |
| ready_o | output | 1 | Array open for normal access |
| rd_en_o | output | 1 | Read passed to the array |
| wr_en_o | output | 1 | Write passed to the array |
| wr_err_o | output | 1 | Sticky: write seen during a restore |
| dirty_o | output | 1 | Array written since the last restore |

## Verification
The bench builds the block with CLEAR_CYCLES at 4 and RECALL_CYCLES at 24. This keeps the whole window, early and late completion, and aborts in each phase within a few dozen cycles. The short clear phase allows a write to be injected during the transfer phase and an abort to be placed both in the clear phase and in the transfer phase. The window is long enough that a copy completing at cycle 10 clearly differs from the window end, so the path where ready waits in hold and the path where it follows the done signal directly are both exercised.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_CLEAR = 3'd1,
    PH_XFER  = 3'd2,
    PH_HOLD  = 3'd3,
    PH_READY = 3'd4
  } phase_e;
endpackage

// File: rtl/prs_req_latch.sv
module prs_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_i,
  input  logic launch_i,
  output logic pend_o
);
  // out of reset counts as a fresh power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_o <= 1'b1;
    else if (below_i)  pend_o <= 1'b1;
    else if (launch_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/prs_recall_timer.sv
module prs_recall_timer #(
  parameter int unsigned CLEAR_CYCLES  = 64,
  parameter int unsigned RECALL_CYCLES = 2000,
  localparam int unsigned CW = $clog2(RECALL_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clr_last_o,
  output logic win_done_o
);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_CYCLES - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(RECALL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q < WIN_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign clr_last_o = (cnt_q == CLR_LAST);
  assign win_done_o = (cnt_q >= WIN_LAST);
endmodule

// File: rtl/prs_phase_fsm.sv
module prs_phase_fsm
  import prs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   below_i,
  input  logic   switch_i,
  input  logic   pend_i,
  input  logic   clr_last_i,
  input  logic   win_done_i,
  input  logic   done_i,
  output phase_e phase_o,
  output logic   launch_o,
  output logic   finish_o
);
  phase_e ph_q, ph_d;

  assign launch_o = (ph_q == PH_WAIT) && pend_i && !below_i && switch_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_WAIT:  if (launch_o) ph_d = PH_CLEAR;
      PH_CLEAR: if (clr_last_i) ph_d = PH_XFER;
      PH_XFER:  if (done_i) ph_d = win_done_i ? PH_READY : PH_HOLD;
      PH_HOLD:  if (win_done_i) ph_d = PH_READY;
      PH_READY: ph_d = PH_READY;
      default:  ph_d = PH_WAIT;
    endcase
    // supply loss overrides every phase
    if (below_i) ph_d = PH_WAIT;
  end

  assign finish_o = (ph_q != PH_READY) && (ph_d == PH_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_WAIT;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/prs_access_gate.sv
module prs_access_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic ready_i,
  input  logic power_ok_i,
  input  logic finish_i,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic wr_err_o,
  output logic dirty_o
);
  logic open_w;
  assign open_w  = ready_i && power_ok_i;
  assign rd_en_o = rd_req_i && open_w;
  assign wr_en_o = wr_req_i && open_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wr_err_o <= 1'b0;
    else if (busy_i && wr_req_i) wr_err_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dirty_o <= 1'b0;
    else if (finish_i) dirty_o <= 1'b0;
    else if (wr_en_o)  dirty_o <= 1'b1;
  end
endmodule

// File: rtl/prs_recall_seq.sv
module prs_recall_seq
  import prs_pkg::*;
#(
  parameter int unsigned CLEAR_CYCLES  = 64,
  parameter int unsigned RECALL_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_reset_i,
  input  logic above_switch_i,
  input  logic xfer_done_i,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic clear_o,
  output logic xfer_o,
  output logic ready_o,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic wr_err_o,
  output logic dirty_o
);
  phase_e phase_w;
  logic   below_w, pend_w, launch_w, finish_w, clr_last_w, win_done_w, busy_w;

  assign below_w = !above_reset_i;

  prs_req_latch u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .below_i  (below_w),
    .launch_i (launch_w),
    .pend_o   (pend_w)
  );

  prs_recall_timer #(
    .CLEAR_CYCLES  (CLEAR_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (phase_w != PH_WAIT),
    .clr_last_o (clr_last_w),
    .win_done_o (win_done_w)
  );

  prs_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .below_i    (below_w),
    .switch_i   (above_switch_i),
    .pend_i     (pend_w),
    .clr_last_i (clr_last_w),
    .win_done_i (win_done_w),
    .done_i     (xfer_done_i),
    .phase_o    (phase_w),
    .launch_o   (launch_w),
    .finish_o   (finish_w)
  );

  assign clear_o = (phase_w == PH_CLEAR);
  assign xfer_o  = (phase_w == PH_XFER);
  assign ready_o = (phase_w == PH_READY);
  assign busy_w  = clear_o || xfer_o || (phase_w == PH_HOLD);

  prs_access_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_w),
    .ready_i    (ready_o),
    .power_ok_i (above_reset_i),
    .finish_i   (finish_w),
    .rd_req_i   (rd_req_i),
    .wr_req_i   (wr_req_i),
    .rd_en_o    (rd_en_o),
    .wr_en_o    (wr_en_o),
    .wr_err_o   (wr_err_o),
    .dirty_o    (dirty_o)
  );
endmodule

// File: rtl/prs_recall_seq_chk.sv
module prs_recall_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic above_reset_i,
  input logic xfer_done_i,
  input logic wr_req_i,
  input logic clear_o,
  input logic xfer_o,
  input logic ready_o,
  input logic wr_en_o,
  input logic rd_en_o,
  input logic wr_err_o,
  input logic dirty_o
);
  assert_one_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clear_o, xfer_o, ready_o}));

  assert_clear_to_xfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o && above_reset_i) |=> (clear_o || xfer_o));

  assert_done_ends_xfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && xfer_done_i && above_reset_i) |=> !xfer_o);

  assert_gate_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || rd_en_o) |-> (ready_o && above_reset_i));

  assert_busy_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clear_o || xfer_o) && wr_req_i) |=> wr_err_o);

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);

  assert_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !above_reset_i |=> (!clear_o && !xfer_o && !ready_o));

  assert_dirty_cleared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !dirty_o);
endmodule

bind prs_recall_seq prs_recall_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .above_reset_i (above_reset_i),
  .xfer_done_i   (xfer_done_i),
  .wr_req_i      (wr_req_i),
  .clear_o       (clear_o),
  .xfer_o        (xfer_o),
  .ready_o       (ready_o),
  .wr_en_o       (wr_en_o),
  .rd_en_o       (rd_en_o),
  .wr_err_o      (wr_err_o),
  .dirty_o       (dirty_o)
);

// File: tb/prs_recall_seq_tb_top.sv
module prs_recall_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLR_N = 4;
  localparam int WIN_N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_reset = 1'b0, above_switch = 1'b0, xfer_done = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic clear_w, xfer_w, ready_w, rd_en_w, wr_en_w, wr_err_w, dirty_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  prs_recall_seq #(.CLEAR_CYCLES(CLR_N), .RECALL_CYCLES(WIN_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .above_reset_i(above_reset), .above_switch_i(above_switch),
    .xfer_done_i(xfer_done), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .clear_o(clear_w), .xfer_o(xfer_w), .ready_o(ready_w),
    .rd_en_o(rd_en_w), .wr_en_o(wr_en_w), .wr_err_o(wr_err_w), .dirty_o(dirty_w)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // event kinds: 0 clr up, 1 clr down, 2 xfer up, 3 xfer down, 4 rdy up, 5 rdy down
  typedef struct { int kind; int at; string req; } ev_t;
  ev_t exp_q[$];

  task automatic expect_ev(int k, int at, string req);
    ev_t e;
    e.kind = k; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic seen(int k);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R2 unexpected event: actual kind %0d at %0d expected none", k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s event: actual kind %0d at %0d expected kind %0d at %0d",
                 e.req, k, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor
  logic pc = 1'b0, px = 1'b0, pr = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (clear_w && !pc) seen(0);
      if (!clear_w && pc) seen(1);
      if (xfer_w && !px)  seen(2);
      if (!xfer_w && px)  seen(3);
      if (ready_w && !pr) seen(4);
      if (!ready_w && pr) seen(5);
    end
    pc = clear_w; px = xfer_w; pr = ready_w;
  end

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // called at a negedge; returns launch edge
  task automatic launch(output int l);
    l = cyc + 1;
    expect_ev(0, l, "R2");
    expect_ev(1, l + CLR_N, "R3");
    expect_ev(2, l + CLR_N, "R3");
    above_reset = 1'b1;
    above_switch = 1'b1;
  endtask

  task automatic pulse_done(int at_ready);
    expect_ev(3, cyc + 1, "R4");
    expect_ev(4, at_ready, (at_ready == cyc + 1) ? "R5" : "R4");
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic power_drop(int k, string req);
    expect_ev(k, cyc + 1, req);
    above_reset = 1'b0;
    above_switch = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "clear", clear_w, 0);
    chk("R1", "xfer", xfer_w, 0);
    chk("R1", "ready", ready_w, 0);
    chk("R1", "wr_err", wr_err_w, 0);
    chk("R1", "dirty", dirty_w, 0);

    // reset level only: must stay idle
    above_reset = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2", "clear without switch", clear_w, 0);

    // restore with early done, write during transfer
    launch(l);
    wait_to(l + 6);
    wr_req = 1'b1;
    #1 chk("R7", "wr_en in restore", wr_en_w, 0);
    @(negedge clk);
    wr_req = 1'b0;
    chk("R7", "wr_err set", wr_err_w, 1);
    wait_to(l + 10);
    pulse_done(l + WIN_N);
    wait_to(l + WIN_N + 2);
    chk("R4", "ready", ready_w, 1);

    // open access, dirty
    rd_req = 1'b1;
    #1 chk("R6", "rd_en open", rd_en_w, 1);
    rd_req = 1'b0;
    wr_req = 1'b1;
    #1 chk("R6", "wr_en open", wr_en_w, 1);
    @(negedge clk);
    wr_req = 1'b0;
    chk("R10", "dirty set", dirty_w, 1);
    chk("R7", "wr_err sticky", wr_err_w, 1);

    // drop while ready, gate closes at once
    expect_ev(5, cyc + 1, "R9");
    above_reset = 1'b0;
    above_switch = 1'b0;
    rd_req = 1'b1;
    #1 chk("R6", "rd_en on supply loss", rd_en_w, 0);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);

    // restore with late done
    launch(l);
    wait_to(l + WIN_N + 6);
    pulse_done(cyc + 1);
    @(negedge clk);
    chk("R10", "dirty cleared", dirty_w, 0);
    chk("R5", "ready", ready_w, 1);
    power_drop(5, "R9");

    // abort in clear phase
    launch(l);
    exp_q.pop_back(); exp_q.pop_back();
    wait_to(l + 2);
    power_drop(1, "R8");
    chk("R8", "clear after abort", clear_w, 0);

    // abort in transfer phase
    launch(l);
    exp_q.pop_back(); exp_q.pop_back();
    expect_ev(1, l + CLR_N, "R3");
    expect_ev(2, l + CLR_N, "R3");
    wait_to(l + CLR_N + 2);
    power_drop(3, "R8");
    chk("R8", "xfer after abort", xfer_w, 0);
    repeat (3) @(negedge clk);

    // full restore after aborts
    launch(l);
    wait_to(l + 8);
    pulse_done(l + WIN_N);
    wait_to(l + WIN_N + 3);
    chk("R9", "ready after repeat", ready_w, 1);

    chk("R2", "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule